// File: doc/BRIEF.md
# Integer ALU with Immediate Extension

This block is the combinational integer datapath of a simple load-store processor core. It takes a first operand, a second operand that is either a register value or a widened 16-bit immediate, and a 4-bit operation code. From these it produces a 32-bit result, an overflow flag and a zero flag in the same cycle. Arithmetic, logical, comparison, shift and upper-immediate operations are all handled here.

The immediate widener chooses its extension from the operation class. Arithmetic and comparison operations get a sign-extended immediate. The bitwise logical operations get a zero-extended one. Overflow is reported only by the two signed arithmetic operations, which lets the surrounding pipeline raise its own trap. The unsigned forms compute the same bits and never flag anything.

Top module: `alu_top`

## Requirements
- R1: Operation codes on `op_code_i` are: 0 signed add, 1 unsigned add, 2 signed subtract, 3 unsigned subtract, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 signed less-than, 9 unsigned less-than, 10 shift left logical, 11 shift right logical, 12 shift right arithmetic, 13 load-upper. The second operand is `opb_reg_i` when `imm_sel_i` is 0 and the extended `imm_i` when it is 1.
- R2: For codes 0 to 3, 8 and 9, the immediate is sign-extended from bit 15. For example, 4 plus immediate 0xFFFF gives 3.
- R3: For codes 4 to 7, the immediate is zero-extended. For example, 0xFFFFFFFF AND immediate 0xFFFF gives 0x0000FFFF.
- R4: `ovf_o` is 1 for signed add in one case: both operands have the same sign and the result's sign differs. For signed subtract it is 1 in one case: the operand signs differ and the result's sign differs from the first operand.
- R5: Unsigned add and subtract give the same 32-bit result as the signed forms, and `ovf_o` stays 0. `ovf_o` is also 0 for every code other than 0 and 2.
- R6: The less-than codes give 1 when the first operand is below the second operand and 0 otherwise. Code 8 compares as two's complement and code 9 compares as unsigned.
- R7: The shifts move `opa_i` by the 5-bit `shamt_i`. Logical shifts fill vacated bits with 0. The arithmetic right shift fills them with copies of bit 31.
- R8: Load-upper returns `imm_i` in bits 31:16 and zeros in bits 15:0, for either value of `imm_sel_i`.
- R9: NOR returns the bitwise complement of the OR of the two operands.
- R10: `zero_o` is 1 exactly when `result_o` is all zeros.
- R11: Codes 14 and 15 are reserved. They give result 0, `ovf_o` 0 and `zero_o` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code_i | input | 4 | Operation select |
| opa_i | input | 32 | First operand |
| opb_reg_i | input | 32 | Second operand from a register |
| imm_i | input | 16 | Immediate field |
| imm_sel_i | input | 1 | 1 selects the extended immediate as the second operand |
| shamt_i | input | 5 | Shift distance |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed add/subtract overflow |
| zero_o | output | 1 | Result equals zero |

## Verification
Add and subtract are tried at the signed limits: 0x7FFFFFFF plus 1, 0x80000000 plus itself, 0x80000000 minus 1, and 0x7FFFFFFF minus -1. These separate a correct overflow rule from one that checks only the carry, and they show that the unsigned forms stay silent on the same bits. Immediates with bit 15 set are applied to both arithmetic and logical codes, which exposes any swap of sign and zero extension. The comparison codes get operand pairs whose signed and unsigned order disagree. The shifts use distances 0, 4, 5, 30 and 31 on values with bit 31 set and clear, which separates zero fill from sign fill.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_DATA_W = 32;
    localparam int ALU_IMM_W  = 16;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_LUI  = 4'd13
    } alu_op_e;

    // Logical class takes a zero-extended immediate (R3)
    function automatic logic op_is_logical(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    endfunction

    function automatic logic op_is_sub(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBU);
    endfunction

    // Only the signed forms may report overflow (R4, R5)
    function automatic logic op_traps(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              sign_ext_i,
    output logic [DATA_W-1:0] ext_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic fill_bit;

    // R2 sign fill, R3 zero fill
    assign fill_bit = sign_ext_i & imm_i[IMM_W-1];
    assign ext_o    = {{PAD_W{fill_bit}}, imm_i};

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;

    // Subtraction as a + ~b + 1
    assign b_eff = sub_i ? ~b_i : b_i;
    assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};

    // Same-sign effective operands whose sum flips sign
    assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [SH_W-1:0]   dist_i,
    input  logic              left_i,
    input  logic              arith_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stage [SH_W+1];
    logic              fill;

    // Left shifts reuse the right-shift stages on a bit-reversed word
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_rev
            assign rev_in[i]  = val_i[DATA_W-1-i];
            assign rev_out[i] = stage[SH_W][DATA_W-1-i];
        end
    endgenerate

    assign fill     = arith_i & ~left_i & val_i[DATA_W-1];
    assign stage[0] = left_i ? rev_in : val_i;

    generate
        for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = dist_i[k]
                ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]}
                : stage[k];
        end
    endgenerate

    assign res_o = left_i ? rev_out : stage[SH_W];

endmodule

// File: rtl/alu_top.sv
module alu_top
    import alu_pkg::*;
#(
    parameter int DATA_W = alu_pkg::ALU_DATA_W,
    parameter int IMM_W  = alu_pkg::ALU_IMM_W
) (
    input  logic [3:0]              op_code_i,
    input  logic [DATA_W-1:0]       opa_i,
    input  logic [DATA_W-1:0]       opb_reg_i,
    input  logic [IMM_W-1:0]        imm_i,
    input  logic                    imm_sel_i,
    input  logic [$clog2(DATA_W)-1:0] shamt_i,
    output logic [DATA_W-1:0]       result_o,
    output logic                    ovf_o,
    output logic                    zero_o
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int LOW_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] sum;
    logic              sum_ovf;
    logic [DATA_W-1:0] shifted;
    logic              lt_signed;
    logic              lt_unsigned;
    logic              shift_left;
    logic              shift_arith;

    assign op = alu_op_e'(op_code_i);

    alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm_i      (imm_i),
        .sign_ext_i (~op_is_logical(op)),
        .ext_o      (imm_wide)
    );

    assign opb = imm_sel_i ? imm_wide : opb_reg_i;

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i   (opa_i),
        .b_i   (opb),
        .sub_i (op_is_sub(op)),
        .sum_o (sum),
        .ovf_o (sum_ovf)
    );

    assign shift_left  = (op == OP_SLL);
    assign shift_arith = (op == OP_SRA);

    alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .val_i   (opa_i),
        .dist_i  (shamt_i),
        .left_i  (shift_left),
        .arith_i (shift_arith),
        .res_o   (shifted)
    );

    assign lt_signed   = $signed(opa_i) < $signed(opb);
    assign lt_unsigned = opa_i < opb;

    always_comb begin
        result_o = '0;
        unique case (op)
            OP_ADD, OP_ADDU,
            OP_SUB, OP_SUBU: result_o = sum;
            OP_AND:          result_o = opa_i & opb;
            OP_OR:           result_o = opa_i | opb;
            OP_XOR:          result_o = opa_i ^ opb;
            OP_NOR:          result_o = ~(opa_i | opb);
            OP_SLT:          result_o = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_SLTU:         result_o = {{(DATA_W-1){1'b0}}, lt_unsigned};
            OP_SLL, OP_SRL,
            OP_SRA:          result_o = shifted;
            OP_LUI:          result_o = {imm_i, {LOW_W{1'b0}}};
            default:         result_o = '0;
        endcase
    end

    assign ovf_o  = op_traps(op) & sum_ovf;
    assign zero_o = (result_o == '0);

endmodule

// File: rtl/alu_top_chk.sv
module alu_top_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic [3:0]        op_code_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] result_o,
    input logic              ovf_o,
    input logic              zero_o
);
    localparam int LOW_W = DATA_W - IMM_W;

    always_comb begin
        AST_OVF_SIGNED_ONLY: assert (!ovf_o || op_code_i == 4'd0 || op_code_i == 4'd2)
            else $error("overflow on non-trapping code"); // R5
        AST_SLT_BOOLEAN: assert (!(op_code_i == 4'd8 || op_code_i == 4'd9)
                                 || result_o[DATA_W-1:1] == '0)
            else $error("compare result wider than one bit"); // R6
        AST_LUI_SHAPE: assert (op_code_i != 4'd13
                               || result_o == {imm_i, {LOW_W{1'b0}}})
            else $error("load-upper shape"); // R8
        AST_ZERO_MATCH: assert (zero_o == (result_o == '0))
            else $error("zero flag mismatch"); // R10
        AST_SRL_TOP_CLEAR: assert (op_code_i != 4'd11 || !opa_i[DATA_W-1]
                                   || result_o[DATA_W-1] == 1'b0 || result_o == opa_i)
            else $error("logical right shift kept sign"); // R7
        AST_RESERVED_QUIET: assert (op_code_i < 4'd14 || (result_o == '0 && !ovf_o))
            else $error("reserved code active"); // R11
    end

endmodule

bind alu_top alu_top_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
    .op_code_i (op_code_i),
    .opa_i     (opa_i),
    .imm_i     (imm_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o),
    .zero_o    (zero_o)
);

// File: tb/alu_top_tb_top.sv
module alu_top_tb_top;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [15:0] imm;
    logic        imm_sel;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        ovf;
    logic        zero;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk; // 200 MHz

    alu_top dut_i (
        .op_code_i (op_code),
        .opa_i     (opa),
        .opb_reg_i (opb),
        .imm_i     (imm),
        .imm_sel_i (imm_sel),
        .shamt_i   (shamt),
        .result_o  (result),
        .ovf_o     (ovf),
        .zero_o    (zero)
    );

    task automatic drive(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic sel, input logic [4:0] sh,
                         input logic [31:0] er, input logic eo, input string tag);
        exp_t e;
        @(negedge clk);
        op_code = c; opa = a; opb = b; imm = im; imm_sel = sel; shamt = sh;
        e.res = er; e.ovf = eo; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: result settles before the posedge following each drive
    always @(posedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            logic ez;
            e  = exp_q.pop_front();
            ez = (e.res == 32'h0);
            checks++;
            if (result !== e.res || ovf !== e.ovf || zero !== ez) begin
                fails++;
                $display("FAIL %s: actual res=%h ovf=%b zero=%b expected res=%h ovf=%b zero=%b",
                         e.tag, result, ovf, zero, e.res, e.ovf, ez);
            end
        end
    end

    initial begin
        op_code = 4'd0; opa = '0; opb = '0; imm = '0; imm_sel = 1'b0; shamt = '0;
        repeat (3) @(posedge clk);
        // Idle inputs: add of zeros gives zero result, flag set
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || ovf !== 1'b0 || zero !== 1'b1) begin
            fails++;
            $display("FAIL R10 idle: actual res=%h ovf=%b zero=%b expected res=0 ovf=0 zero=1",
                     result, ovf, zero);
        end
        rst_n = 1'b1;
        drive(4'd0, 32'd5, 32'd7, 16'h0, 1'b0, 5'd0, 32'd12, 1'b0, "R1 add");
        drive(4'd0, 32'h7FFFFFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h80000000, 1'b1, "R4 add pos ovf");
        drive(4'd0, 32'h80000000, 32'h80000000, 16'h0, 1'b0, 5'd0, 32'h0, 1'b1, "R4 add neg ovf R10");
        drive(4'd0, 32'hFFFFFFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h0, 1'b0, "R4 add no ovf");
        drive(4'd2, 32'd4, 32'd1, 16'h0, 1'b0, 5'd0, 32'd3, 1'b0, "R1 sub");
        drive(4'd2, 32'h80000000, 32'd1, 16'h0, 1'b0, 5'd0, 32'h7FFFFFFF, 1'b1, "R4 sub ovf a");
        drive(4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 1'b0, 5'd0, 32'h80000000, 1'b1, "R4 sub ovf b");
        drive(4'd2, 32'd5, 32'd5, 16'h0, 1'b0, 5'd0, 32'h0, 1'b0, "R10 sub zero");
        drive(4'd1, 32'h7FFFFFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h80000000, 1'b0, "R5 addu");
        drive(4'd3, 32'h80000000, 32'd1, 16'h0, 1'b0, 5'd0, 32'h7FFFFFFF, 1'b0, "R5 subu");
        drive(4'd0, 32'd4, 32'hDEAD0000, 16'hFFFF, 1'b1, 5'd0, 32'd3, 1'b0, "R2 add imm");
        drive(4'd2, 32'd0, 32'h0, 16'h8000, 1'b1, 5'd0, 32'h00008000, 1'b0, "R2 sub imm");
        drive(4'd4, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'h0000FFFF, 1'b0, "R3 and imm");
        drive(4'd5, 32'h12340000, 32'h0, 16'h8001, 1'b1, 5'd0, 32'h12348001, 1'b0, "R3 or imm");
        drive(4'd6, 32'hFFFF0000, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'hFFFFFFFF, 1'b0, "R3 xor imm");
        drive(4'd8, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'd1, 1'b0, "R6 slt imm R2");
        drive(4'd9, 32'd5, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'd1, 1'b0, "R6 sltu imm R2");
        drive(4'd8, 32'h80000000, 32'd1, 16'h0, 1'b0, 5'd0, 32'd1, 1'b0, "R6 slt signed");
        drive(4'd9, 32'h80000000, 32'd1, 16'h0, 1'b0, 5'd0, 32'd0, 1'b0, "R6 sltu unsigned");
        drive(4'd8, 32'd4, 32'd1, 16'h0, 1'b0, 5'd0, 32'd0, 1'b0, "R6 slt false");
        drive(4'd10, 32'd1, 32'h0, 16'h0, 1'b0, 5'd5, 32'h00000020, 1'b0, "R7 sll");
        drive(4'd10, 32'hFFFFFFFF, 32'h0, 16'h0, 1'b0, 5'd0, 32'hFFFFFFFF, 1'b0, "R7 sll zero dist");
        drive(4'd11, 32'h80000000, 32'h0, 16'h0, 1'b0, 5'd31, 32'd1, 1'b0, "R7 srl");
        drive(4'd12, 32'h80000000, 32'h0, 16'h0, 1'b0, 5'd4, 32'hF8000000, 1'b0, "R7 sra neg");
        drive(4'd12, 32'h40000000, 32'h0, 16'h0, 1'b0, 5'd30, 32'd1, 1'b0, "R7 sra pos");
        drive(4'd13, 32'hFFFFFFFF, 32'h0, 16'h1234, 1'b1, 5'd0, 32'h12340000, 1'b0, "R8 lui");
        drive(4'd13, 32'h0, 32'hFFFFFFFF, 16'hABCD, 1'b0, 5'd0, 32'hABCD0000, 1'b0, "R8 lui reg sel");
        drive(4'd7, 32'h0F0F0000, 32'h00F0F0F0, 16'h0, 1'b0, 5'd0, 32'hF0000F0F, 1'b0, "R9 nor");
        drive(4'd7, 32'h0, 32'h0, 16'h8000, 1'b1, 5'd0, 32'hFFFF7FFF, 1'b0, "R9 nor imm R3");
        drive(4'd4, 32'hF0F0F0F0, 32'h0F0F0F0F, 16'h0, 1'b0, 5'd0, 32'h0, 1'b0, "R10 and zero");
        drive(4'd14, 32'h12345678, 32'h1, 16'h0, 1'b0, 5'd0, 32'h0, 1'b0, "R11 code 14");
        drive(4'd15, 32'h7FFFFFFF, 32'd1, 16'hFFFF, 1'b1, 5'd3, 32'h0, 1'b0, "R11 code 15");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (R1): actual queue=%0d expected empty", exp_q.size());
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule